// File: doc/BRIEF.md
# Dual strobed 2-to-4 decoder / demultiplexer

The block holds two 1-to-4 demultiplexer sections that share a single 2-bit select. Each section has its own active-low enable and its own data input. The low section (index 0) drives outputs 0 to 3 and takes its data active-low. The high section (index 1) drives outputs 4 to 7 and takes its data active-high. All eight outputs are active-low. The result is captured in an output register with a synchronous active-high reset, so every output appears one clock after its inputs.

A build parameter selects the combined mode. In that mode the two enables are driven from `sec_en_n[0]` and the two data inputs from `sec_data[0]`. Because the two sections take their data with opposite polarity, the shared data bit becomes the address MSB of a 3-to-8 decode and needs no extra gating. If `sec_en_n[0]` is used as the data line and `{sec_data[0], sel}` as the address, the same build works as a 1-to-8 demultiplexer.

Top module: `dual_strobe_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, all bits of `y_n` become 1 after that edge, whatever the other inputs are.
- R2: `y_n` changes only at a rising clock edge. It shows the decode of the inputs sampled at that edge, so the latency is one cycle.
- R3: Dual mode: when `sec_en_n[0]` is 1, `y_n[3:0]` is all ones.
- R4: Dual mode: when `sec_en_n[0]` is 0 and `sec_data[0]` is 0, only `y_n[sel]` of `y_n[3:0]` is 0, where `sel[1]` is the MSB. When `sec_data[0]` is 1, `y_n[3:0]` is all ones.
- R5: Dual mode: when `sec_en_n[1]` is 1, `y_n[7:4]` is all ones.
- R6: Dual mode: when `sec_en_n[1]` is 0 and `sec_data[1]` is 1, only `y_n[4+sel]` of `y_n[7:4]` is 0. When `sec_data[1]` is 0, `y_n[7:4]` is all ones.
- R7: Dual mode: each 4-bit half of `y_n` has at most one bit at 0.
- R8: Combined mode: when `sec_en_n[0]` is 0, exactly one output is 0, namely `y_n[{sec_data[0], sel}]`. `sec_en_n[1]` and `sec_data[1]` have no effect.
- R9: Combined mode: when `sec_en_n[0]` is 1, all of `y_n` is 1.
- R10: Combined mode as a 1-to-8 demultiplexer: with the address `{sec_data[0], sel}` held fixed, the addressed output follows `sec_en_n[0]` and every other output stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | SEL_W (2) | Shared select, bit 1 is MSB |
| sec_en_n | input | 2 | Active-low enable per section; bit 0 low section, bit 1 high section |
| sec_data | input | 2 | Data per section; bit 0 active-low, bit 1 active-high |
| y_n | output | 2*2^SEL_W (8) | Active-low outputs; [3:0] low section, [7:4] high section |

## Verification
Every decode result is due exactly one rising edge after the inputs it depends on. The bench drives inputs on the falling edge and compares outputs on the next falling edge, which puts exactly one register stage between stimulus and sample. Right after driving, it also checks that the outputs still hold their previous value, so a path that skipped the register would be caught. The dual build is swept over all 64 combinations of select, enables and data. The combined build is swept over the same 64, with the two ignored bits varied as well, and runs a demultiplexer pass that toggles the data line at every address.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int unsigned SECTIONS = 2;
endpackage

// File: rtl/dmx_section.sv
module dmx_section #(
  parameter int SEL_W         = 2,
  parameter bit DATA_ACT_HIGH = 1'b0,
  localparam int OUTS         = 1 << SEL_W
) (
  input  logic             en_n,
  input  logic             data,
  input  logic [SEL_W-1:0] sel,
  output logic [OUTS-1:0]  y_n
);
  logic live;

  // data polarity chosen per section
  generate
    if (DATA_ACT_HIGH) begin : g_pos
      assign live = !en_n && data;
    end else begin : g_neg
      assign live = !en_n && !data;
    end
  endgenerate

  always_comb begin
    y_n = '1;
    if (live) y_n[sel] = 1'b0;
  end
endmodule

// File: rtl/dmx_outreg.sv
module dmx_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= d;
  end
endmodule

// File: rtl/dual_strobe_decoder.sv
module dual_strobe_decoder
  import dmx_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter bit COMBINED = 1'b0,
  localparam int OUTS    = 1 << SEL_W,
  localparam int YW      = SECTIONS * OUTS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel,
  input  logic [SECTIONS-1:0] sec_en_n,
  input  logic [SECTIONS-1:0] sec_data,
  output logic [YW-1:0]       y_n
);
  logic [SECTIONS-1:0] en_route;
  logic [SECTIONS-1:0] data_route;
  logic [YW-1:0]       y_comb;

  // combined mode ties the section inputs together
  generate
    if (COMBINED) begin : g_tie
      assign en_route   = {SECTIONS{sec_en_n[0]}};
      assign data_route = {SECTIONS{sec_data[0]}};
    end else begin : g_split
      assign en_route   = sec_en_n;
      assign data_route = sec_data;
    end
  endgenerate

  generate
    for (genvar g = 0; g < SECTIONS; g++) begin : g_sec
      dmx_section #(
        .SEL_W        (SEL_W),
        .DATA_ACT_HIGH(g == 1)
      ) u_sec (
        .en_n(en_route[g]),
        .data(data_route[g]),
        .sel (sel),
        .y_n (y_comb[g*OUTS +: OUTS])
      );
    end
  endgenerate

  dmx_outreg #(.W(YW)) u_oreg (
    .clk(clk),
    .rst(rst),
    .d  (y_comb),
    .q  (y_n)
  );

  assert_rst_idle_R1: assert property (@(posedge clk) rst |=> (y_n == '1));

  generate
    if (COMBINED) begin : g_chk_comb
      assert_comb_hit_R8: assert property (@(posedge clk) disable iff (rst)
        !sec_en_n[0] |=> ($countones(~y_n) == 1) && !y_n[{$past(sec_data[0]), $past(sel)}]);
      assert_comb_off_R9: assert property (@(posedge clk) disable iff (rst)
        sec_en_n[0] |=> (y_n == '1));
    end else begin : g_chk_dual
      assert_lo_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        sec_en_n[0] |=> (y_n[OUTS-1:0] == '1));
      assert_lo_data_R4: assert property (@(posedge clk) disable iff (rst)
        (!sec_en_n[0] && sec_data[0]) |=> (y_n[OUTS-1:0] == '1));
      assert_hi_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        sec_en_n[1] |=> (y_n[YW-1:OUTS] == '1));
      assert_hi_data_R6: assert property (@(posedge clk) disable iff (rst)
        (!sec_en_n[1] && !sec_data[1]) |=> (y_n[YW-1:OUTS] == '1));
      assert_one_low_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~y_n[OUTS-1:0]) && $onehot0(~y_n[YW-1:OUTS]));
    end
  endgenerate
endmodule

// File: tb/tb_dual_strobe_decoder.sv
module tb_dual_strobe_decoder;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_a = '0, en_a = '1, dat_a = '0;
  logic [1:0] sel_b = '0, en_b = '1, dat_b = '0;
  logic [7:0] y_a, y_b;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dual_strobe_decoder #(.SEL_W(2), .COMBINED(1'b0)) dut (
    .clk(clk), .rst(rst), .sel(sel_a), .sec_en_n(en_a), .sec_data(dat_a), .y_n(y_a));

  dual_strobe_decoder #(.SEL_W(2), .COMBINED(1'b1)) dut_comb (
    .clk(clk), .rst(rst), .sel(sel_b), .sec_en_n(en_b), .sec_data(dat_b), .y_n(y_b));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input logic live, input logic [1:0] s);
    nib = live ? (4'hF ^ (4'h1 << s)) : 4'hF;
  endfunction

  function automatic logic [7:0] exp_dual(input logic [1:0] en, input logic [1:0] d, input logic [1:0] s);
    exp_dual = {nib(!en[1] && d[1], s), nib(!en[0] && !d[0], s)};
  endfunction

  function automatic logic [7:0] exp_comb(input logic en, input logic d, input logic [1:0] s);
    exp_comb = en ? 8'hFF : (8'hFF ^ (8'h1 << {d, s}));
  endfunction

  initial begin
    #(PERIOD * WATCHDOG_CYC);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dual reset", y_a, 8'hFF);
    chk("R1 comb reset", y_b, 8'hFF);
    rst = 1'b0;
    // R2: drive, confirm no change before the edge, then change after it
    en_a = 2'b00; dat_a = 2'b10; sel_a = 2'd2;
    #1 chk("R2 dual hold before edge", y_a, 8'hFF);
    @(negedge clk);
    chk("R2 dual one-cycle result", y_a, exp_dual(2'b00, 2'b10, 2'd2));

    // dual sweep: 64 combinations
    for (int i = 0; i < 64; i++) begin
      sel_a = i[1:0]; en_a = i[3:2]; dat_a = i[5:4];
      @(negedge clk);
      begin
        logic [7:0] e;
        e = exp_dual(i[3:2], i[5:4], i[1:0]);
        chk(i[2] ? "R3 low section disabled" : "R4 low section decode", {4'h0, y_a[3:0]}, {4'h0, e[3:0]});
        chk(i[3] ? "R5 high section disabled" : "R6 high section decode", {4'h0, y_a[7:4]}, {4'h0, e[7:4]});
        chk("R7 at most one low per half",
            {6'h0, ($countones(~y_a[3:0]) <= 1), ($countones(~y_a[7:4]) <= 1)}, 8'h03);
      end
    end

    // combined sweep: ignored bits [1] varied too
    for (int i = 0; i < 64; i++) begin
      sel_b = i[1:0]; dat_b = {i[4], i[2]}; en_b = {i[5], i[3]};
      @(negedge clk);
      chk(i[3] ? "R9 combined disabled" : "R8 combined 3-to-8 decode", y_b, exp_comb(i[3], i[2], i[1:0]));
    end

    // demultiplexer use: address fixed, data on the enable line
    for (int a = 0; a < 8; a++) begin
      dat_b = {1'b0, a[2]}; sel_b = a[1:0];
      for (int k = 0; k < 4; k++) begin
        en_b = {1'b1, k[0]};
        @(negedge clk);
        chk("R10 demux output follows data", y_b, k[0] ? 8'hFF : (8'hFF ^ (8'h1 << a)));
      end
    end

    // mid-run reset with active inputs
    en_a = 2'b00; dat_a = 2'b10; en_b = 2'b00; dat_b = 2'b01; rst = 1'b1;
    @(negedge clk);
    chk("R1 dual reset overrides", y_a, 8'hFF);
    chk("R1 comb reset overrides", y_b, 8'hFF);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 comb resumes after reset", y_b, exp_comb(1'b0, 1'b1, sel_b));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule